// File: doc/BRIEF.md
# Ramp-Compare Conversion Sequencer

This block sequences a single-slope (ramp-compare) conversion entirely in logic. A 7-bit ramp register stands in for a falling reference voltage. It starts at full scale and steps down by one on each clock while a conversion runs. A digital input code takes the place of the sampled voltage, and a magnitude comparator reports whether the ramp is still at or above that code. A second register counts up in lockstep with the ramp. A count/pause state bit stops both registers as soon as the comparator drops, so the value left in the up-counter is the converted result.

A conversion is requested by pulling `start_n` low, for example from a push-button. The request passes through a two-stage synchronizer. While the request is held, the ramp sits at full scale, the result sits at zero and the sequencer is in the count state. Releasing the request lets the ramp run. If the ramp reaches zero without the comparator falling, which happens only for an input code of zero, the sequencer pauses with a full-scale result. An active-low asynchronous reset puts the block into the idle pause state.

Top module: `ramp_adc_seq`

## Requirements
- R1: After reset, `busy` is 0, `result` is 0 and `cmp_out` is 1.
- R2: `start_n` is synchronized by two flip-flops. A low level sampled at a rising edge first affects `busy` and `result` at the third rising edge, counting that first edge.
- R3: While the synchronized request is held, `busy` is 1, `result` is 0 and the ramp stays at full scale (127), so `cmp_out` is 1 for any code.
- R4: `cmp_out` is 1 exactly when the ramp value is greater than or equal to `code_in`. The ramp value always equals 127 minus `result`.
- R5: For an input code c from 1 to 127, the conversion pauses with `result` = 128 - c and `cmp_out` = 0.
- R6: For input code 0, the ramp reaches 0 and the sequencer pauses with `result` = 127 and `cmp_out` still 1.
- R7: After the release of `start_n`, `busy` stays high for exactly S + 2 clock cycles, where S is the number of steps taken. S is 128 - c for a code c of 1 or more, and 127 for code 0. A full-scale run therefore spans 128 clocks after the synchronized release.
- R8: In the pause state, changes on `code_in` leave `result` and `busy` unchanged until the next start request.
- R9: A start request applied during a conversion restarts it: `result` returns to 0, `busy` stays 1, and the following conversion completes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Asynchronous active-low conversion request |
| code_in | input | 7 | Digital input compared against the ramp |
| result | output | 7 | Up-counter value; the converted code in pause |
| busy | output | 1 | High while in the count state |
| cmp_out | output | 1 | Comparator: ramp greater than or equal to `code_in` |

## Verification
On every cycle, the in-line assertions check the following:
- The ramp and the result always sum to full scale.
- A held request forces a zeroed result and the count state.
- A low comparator or an exhausted ramp ends the count state on the next edge.
- The result holds steady once the sequencer has paused.

Only the bench's sweep can show the latency of the synchronizer, the exact busy duration for each of the 128 input codes, the converted value itself, the full-scale case for code zero, and the restart when a request is applied mid-conversion.

// File: rtl/ramp_adc_seq.sv
module ramp_adc_seq #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_n,
  input  logic [W-1:0] code_in,
  output logic [W-1:0] result,
  output logic         busy,
  output logic         cmp_out
);

  localparam logic [W-1:0] TOP = '1;

  logic         s1, s2, req;
  logic [W-1:0] ramp;
  logic         step, stop;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= start_n;
      s2 <= s1;
    end

  assign req     = ~s2;
  assign cmp_out = (ramp >= code_in);
  assign step    = busy & ~req & cmp_out & (ramp != '0);
  assign stop    = busy & ~req & (~cmp_out | (ramp == '0));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ramp   <= TOP;
      result <= '0;
      busy   <= 1'b0;
    end else if (req) begin
      ramp   <= TOP;
      result <= '0;
      busy   <= 1'b1;
    end else begin
      if (step) begin
        ramp   <= ramp - 1'b1;
        result <= result + 1'b1;
      end
      if (stop) busy <= 1'b0;
    end

  assert_lockstep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, ramp} + {1'b0, result}) == {1'b0, TOP});

  assert_hold_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (busy && result == '0 && ramp == TOP));

  assert_cmp_low_pauses_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !req && !cmp_out) |=> !busy);

  assert_ramp_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp == '0 && !req) |=> (ramp == '0 && !busy));

  assert_pause_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req) |=> $stable(result));

endmodule

// File: tb/ramp_adc_seq_bench.sv
module ramp_adc_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_n = 1'b1;
  logic [6:0] code_in = '0;
  logic [6:0] result;
  logic       busy, cmp_out;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  ramp_adc_seq #(.W(7)) u_ramp_adc_seq (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .code_in(code_in),
    .result(result), .busy(busy), .cmp_out(cmp_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic convert(input int c);
    int cnt, steps, expr;
    bit done;
    code_in = 7'(c);
    start_n = 1'b0;
    tick(2);
    chk(busy == 1'b0, "R2 busy before sync latency", busy, 0);
    tick(1);
    chk(busy == 1'b1, "R2 busy after third edge", busy, 1);
    chk(result == 0, "R3 result held at zero", result, 0);
    tick(2);
    chk(cmp_out == 1'b1, "R3 comparator high at full ramp", cmp_out, 1);
    chk(busy == 1'b1 && result == 0, "R3 hold state", result, 0);
    start_n = 1'b1;
    cnt = 0;
    done = 0;
    while (!done && cnt < 300) begin
      tick(1);
      if (busy) cnt++;
      else done = 1;
    end
    steps = (c == 0) ? 127 : 128 - c;
    expr  = (c == 0) ? 127 : 128 - c;
    chk(cnt == steps + 2, "R7 busy duration", cnt, steps + 2);
    if (c == 0) begin
      chk(result == 127, "R6 full-scale result", result, 127);
      chk(cmp_out == 1'b1, "R6 comparator high at floor", cmp_out, 1);
    end else begin
      chk(result == 7'(expr), "R5 converted result", result, expr);
      chk(cmp_out == 1'b0, "R5 comparator low at pause", cmp_out, 0);
    end
    chk(cmp_out == ((127 - int'(result)) >= c), "R4 comparator vs ramp",
        cmp_out, ((127 - int'(result)) >= c));
    code_in = 7'(c ^ 7'h55);
    tick(3);
    chk(result == 7'(expr) && busy == 1'b0, "R8 pause ignores code", result, expr);
    chk(cmp_out == ((127 - int'(result)) >= int'(code_in)), "R4 comparator follows code",
        cmp_out, ((127 - int'(result)) >= int'(code_in)));
  endtask

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    chk(result == 0, "R1 reset result", result, 0);
    chk(cmp_out == 1'b1, "R1 reset comparator", cmp_out, 1);

    for (int c = 0; c < 128; c++) convert(c);

    code_in = 7'd10;
    start_n = 1'b0;
    tick(4);
    start_n = 1'b1;
    tick(20);
    chk(busy == 1'b1 && result != 0, "R9 mid-conversion", result, 18);
    start_n = 1'b0;
    tick(3);
    chk(result == 0, "R9 restart clears result", result, 0);
    chk(busy == 1'b1, "R9 restart keeps busy", busy, 1);
    start_n = 1'b1;
    tick(130);
    chk(result == 118, "R9 restarted conversion result", result, 118);
    chk(busy == 1'b0, "R9 restarted conversion paused", busy, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule